// File: doc/BRIEF.md
# Privilege-Stack Trap and Interrupt Unit

This block keeps the machine status word of a small processor core. The status word carries a three-level stack of privilege-level and interrupt-enable pairs, plus a memory-privilege override bit. When the core raises an exception, or when a pending and enabled interrupt is allowed at the current privilege, the unit pushes the stack. It then records the cause and the faulting PC and presents a trap vector that depends on the privilege level in effect before the push. A trap-return request pops the stack and refills the deepest slot with fixed values.

The unit also holds the software-writable interrupt pending bits, the interrupt enable bits and a timer compare register. The machine timer pending bit is set from a comparison against a free-running real-time counter supplied by the core. All state changes take effect on the clock edge that follows the request. Every output is a register.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset the status word reads 0x96: current privilege machine (3), stack levels 1 and 2 supervisor (1), all enables and the override bit clear. vec_pc_o reads VEC_BASE+0x100, and cause_o, epc_o, pending_o, enable_o and trap_fire_o read zero.
- R2: Status layout: level k (k = 0 current, 1, 2) has its enable at bit 3k and its 2-bit privilege at bits 3k+2:3k+1, and the override bit is bit 9. Privilege codes are user 0, supervisor 1, machine 3. A taken trap moves level 1 into level 2 and level 0 into level 1, then sets level 0 to machine with its enable clear, and clears the override bit.
- R3: A taken trap sets vec_pc_o to VEC_BASE + 0x40 × (privilege before the push), stores the cause in cause_o and stores cur_pc in epc_o.
- R4: A trap return moves level 1 into level 0 and level 2 into level 1, and refills level 2 with user privilege and enable 1. vec_pc_o, cause_o and epc_o keep their values.
- R5: Priority within one cycle, from highest: exception request, interrupt, trap return, status write. A losing return or status write has no effect. An exception that coincides with an allowed interrupt records the exception cause.
- R6: Machine-tier interrupts are allowed when the privilege is below machine, or is machine with the current enable set. They are checked in this order: machine software, machine timer, then host message nonzero.
- R7: Supervisor-tier interrupts are allowed when the privilege is user, or is supervisor with the current enable set. Supervisor software is checked before supervisor timer. Every machine-tier source is checked before any supervisor-tier one.
- R8: A pending bit counts only with its enable bit set; the host flag needs no enable. An interrupt cause has bit XLEN-1 set and the code in the low bits: software 0, timer 1, host 2.
- R9: The machine timer pending bit (pending bit 7) is set on the edge after rtc is greater than or equal to the compare value. It stays set until a compare write, which clears it on that write's edge. The compare register resets to all ones.
- R10: A status write updates each privilege field only when the written code is 0, 1 or 3. A written code 2 leaves that field unchanged. Enables and the override bit are always written.
- R11: A pending write changes only bits 1 (supervisor software), 3 (machine software) and 5 (supervisor timer), and the machine timer bit is not writable. An enable write changes only bits 1, 3, 5 and 7.
- R12: trap_fire_o is high for exactly the one cycle following each taken trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Exception request from the core |
| trap_cause | input | XLEN | Exception cause code |
| cur_pc | input | XLEN | PC of the instruction being trapped |
| ret_req | input | 1 | Trap-return request |
| host_msg_nz | input | 1 | Host message register is nonzero |
| rtc | input | XLEN | Real-time counter value |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Write target: 0 status, 1 pending, 2 enable, 3 timer compare |
| csr_wdata | input | XLEN | Write data |
| status_o | output | XLEN | Status word |
| pending_o | output | XLEN | Interrupt pending bits |
| enable_o | output | XLEN | Interrupt enable bits |
| cause_o | output | XLEN | Last trap cause |
| epc_o | output | XLEN | Last trapped PC |
| vec_pc_o | output | XLEN | Redirect PC (trap vector, or start address after reset) |
| trap_fire_o | output | 1 | One-cycle pulse after a taken trap |

## Verification
A corrupted stack slot shows on status_o on the edge after the push or pop that moves it. It also shows one operation later when that slot reaches level 0, because the vector offset in vec_pc_o depends on it. A wrong arbitration order or tier gate shows in cause_o and trap_fire_o one cycle after the enable or status write that arms the interrupt. A timer bit that fails to set, fails to stick or fails to clear shows on pending_o bit 7 one edge after the rtc change or compare write.

// File: rtl/trapu_pkg.sv
`timescale 1ns/1ps
package trapu_pkg;
  // Privilege encodings (code 2 is never stored)
  localparam logic [1:0] PRV_U   = 2'd0;
  localparam logic [1:0] PRV_S   = 2'd1;
  localparam logic [1:0] PRV_RSV = 2'd2;
  localparam logic [1:0] PRV_M   = 2'd3;

  // Status word layout: one 3-bit slot per stack level, override bit after
  localparam int unsigned STACK_DEPTH = 3;
  localparam int unsigned SLOT_W      = 3;
  localparam int unsigned BIT_MPRV    = STACK_DEPTH * SLOT_W;
  localparam int unsigned STAT_W      = BIT_MPRV + 1;

  // Pending / enable bit positions
  localparam int unsigned PB_SSIP = 1;
  localparam int unsigned PB_MSIP = 3;
  localparam int unsigned PB_STIP = 5;
  localparam int unsigned PB_MTIP = 7;

  // Interrupt codes
  localparam int unsigned CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_SW   = 2'd0;
  localparam logic [CODE_W-1:0] CODE_TMR  = 2'd1;
  localparam logic [CODE_W-1:0] CODE_HOST = 2'd2;

  // Write targets
  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_PEND   = 2'd1;
  localparam logic [1:0] SEL_ENAB   = 2'd2;
  localparam logic [1:0] SEL_TCMP   = 2'd3;

  typedef struct packed {
    logic m_tmr;
    logic m_sw;
    logic s_tmr;
    logic s_sw;
  } irq_bits_t;
endpackage

// File: rtl/trapu_status.sv
`timescale 1ns/1ps
module trapu_status
  import trapu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_go,
  input  logic              ret_go,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [1:0]        prv_o,
  output logic              ie_o,
  output logic [XLEN-1:0]   status_o
);
  localparam int unsigned TOP = STACK_DEPTH - 1;

  logic [TOP:0][1:0] prv_q, prv_d, wr_prv;
  logic [TOP:0]      ie_q, ie_d, wr_ie;
  logic              mprv_q, mprv_d;
  logic              upd_en;

  // Write filter: a reserved privilege code keeps the old field
  for (genvar l = 0; l < STACK_DEPTH; l++) begin : g_wfilt
    localparam int unsigned BASE = l * SLOT_W;
    logic [1:0] raw;
    assign raw       = wr_data[BASE+2:BASE+1];
    assign wr_ie[l]  = wr_data[BASE];
    assign wr_prv[l] = (raw == PRV_RSV) ? prv_q[l] : raw;
  end

  assign upd_en = trap_go | ret_go | wr_en;

  always_comb begin
    prv_d  = prv_q;
    ie_d   = ie_q;
    mprv_d = mprv_q;
    if (trap_go) begin
      for (int l = TOP; l > 0; l--) begin
        prv_d[l] = prv_q[l-1];
        ie_d[l]  = ie_q[l-1];
      end
      prv_d[0] = PRV_M;
      ie_d[0]  = 1'b0;
      mprv_d   = 1'b0;
    end else if (ret_go) begin
      for (int l = 0; l < TOP; l++) begin
        prv_d[l] = prv_q[l+1];
        ie_d[l]  = ie_q[l+1];
      end
      prv_d[TOP] = PRV_U;
      ie_d[TOP]  = 1'b1;
    end else if (wr_en) begin
      prv_d  = wr_prv;
      ie_d   = wr_ie;
      mprv_d = wr_data[BIT_MPRV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < STACK_DEPTH; l++) begin
        prv_q[l] <= (l == 0) ? PRV_M : PRV_S;
      end
      ie_q   <= '0;
      mprv_q <= 1'b0;
    end else if (upd_en) begin
      prv_q  <= prv_d;
      ie_q   <= ie_d;
      mprv_q <= mprv_d;
    end
  end

  always_comb begin
    status_o = '0;
    for (int l = 0; l < STACK_DEPTH; l++) begin
      status_o[l*SLOT_W]          = ie_q[l];
      status_o[l*SLOT_W+1 +: 2]   = prv_q[l];
    end
    status_o[BIT_MPRV] = mprv_q;
  end

  assign prv_o = prv_q[0];
  assign ie_o  = ie_q[0];

  // R2: push shifts the stack and enters machine mode with enables off
  assert_stack_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> (prv_q[0] == PRV_M) && !ie_q[0] && !mprv_q &&
                (prv_q[1] == $past(prv_q[0])) && (ie_q[1] == $past(ie_q[0])) &&
                (prv_q[2] == $past(prv_q[1])));

  // R4: pop refills the deepest slot with user / enabled
  assert_stack_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_go && !trap_go) |=> (prv_q[TOP] == PRV_U) && ie_q[TOP] &&
                             (prv_q[0] == $past(prv_q[1])));

  // R10: the reserved privilege code never reaches the register
  assert_no_rsv_prv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prv_q[0] != PRV_RSV) && (prv_q[1] != PRV_RSV) && (prv_q[2] != PRV_RSV));
endmodule

// File: rtl/trapu_timer.sv
`timescale 1ns/1ps
module trapu_timer #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] rtc,
  input  logic            cmp_we,
  input  logic [XLEN-1:0] cmp_wdata,
  output logic            mtip_o
);
  logic [XLEN-1:0] cmp_q, cmp_d;
  logic            mtip_q, mtip_d;
  logic            reached;

  assign reached = (rtc >= cmp_q);

  always_comb begin
    cmp_d  = cmp_we ? cmp_wdata : cmp_q;
    mtip_d = cmp_we ? 1'b0 : (mtip_q | reached);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      mtip_q <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_d;
      mtip_q <= mtip_d;
    end
  end

  assign mtip_o = mtip_q;

  // R9: reaching the compare value sets the bit unless a compare write clears it
  assert_mtip_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_we && reached) |=> mtip_q);

  assert_mtip_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !mtip_q);

  assert_mtip_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mtip_q && !cmp_we) |=> mtip_q);
endmodule

// File: rtl/trapu_arb.sv
`timescale 1ns/1ps
module trapu_arb
  import trapu_pkg::*;
(
  input  logic [1:0]        prv,
  input  logic              ie,
  input  irq_bits_t         live,
  input  logic              host_nz,
  output logic              irq_valid,
  output logic [CODE_W-1:0] irq_code
);
  logic m_open, s_open;

  assign m_open = (prv < PRV_M) || ((prv == PRV_M) && ie);
  assign s_open = (prv < PRV_S) || ((prv == PRV_S) && ie);

  always_comb begin
    irq_valid = 1'b1;
    irq_code  = CODE_SW;
    if (m_open && live.m_sw) begin
      irq_code = CODE_SW;
    end else if (m_open && live.m_tmr) begin
      irq_code = CODE_TMR;
    end else if (m_open && host_nz) begin
      irq_code = CODE_HOST;
    end else if (s_open && live.s_sw) begin
      irq_code = CODE_SW;
    end else if (s_open && live.s_tmr) begin
      irq_code = CODE_TMR;
    end else begin
      irq_valid = 1'b0;
    end
  end
endmodule

// File: rtl/priv_trap_unit.sv
`timescale 1ns/1ps
module priv_trap_unit
  import trapu_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] VEC_BASE = 'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            ret_req,
  input  logic            host_msg_nz,
  input  logic [XLEN-1:0] rtc,
  input  logic            csr_we,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] pending_o,
  output logic [XLEN-1:0] enable_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] vec_pc_o,
  output logic            trap_fire_o
);
  localparam int unsigned     VEC_SHIFT = 6;
  localparam logic [XLEN-1:0] START_PC  = VEC_BASE + XLEN'(256);

  // ---- write decode ----
  logic wr_status, wr_pend, wr_enab, wr_tcmp;
  assign wr_status = csr_we && (csr_sel == SEL_STATUS);
  assign wr_pend   = csr_we && (csr_sel == SEL_PEND);
  assign wr_enab   = csr_we && (csr_sel == SEL_ENAB);
  assign wr_tcmp   = csr_we && (csr_sel == SEL_TCMP);

  // ---- decision ----
  logic              irq_valid, irq_go, exc_go, take_any, ret_go;
  logic [CODE_W-1:0] irq_code;
  logic [1:0]        prv_cur;
  logic              ie_cur;
  logic              mtip;
  irq_bits_t         live;

  assign exc_go   = trap_req;
  assign irq_go   = irq_valid && !trap_req;
  assign take_any = exc_go || irq_go;
  assign ret_go   = ret_req && !take_any;

  // ---- status stack ----
  trapu_status #(.XLEN(XLEN)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_go  (take_any),
    .ret_go   (ret_go),
    .wr_en    (wr_status),
    .wr_data  (csr_wdata[STAT_W-1:0]),
    .prv_o    (prv_cur),
    .ie_o     (ie_cur),
    .status_o (status_o)
  );

  // ---- timer ----
  trapu_timer #(.XLEN(XLEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rtc       (rtc),
    .cmp_we    (wr_tcmp),
    .cmp_wdata (csr_wdata),
    .mtip_o    (mtip)
  );

  // ---- pending (software bits) and enable registers ----
  logic [2:0] pend_q, pend_d;   // {stip, msip, ssip}
  logic [3:0] enab_q, enab_d;   // {mtie, stie, msie, ssie}

  always_comb begin
    pend_d = pend_q;
    enab_d = enab_q;
    if (wr_pend) pend_d = {csr_wdata[PB_STIP], csr_wdata[PB_MSIP], csr_wdata[PB_SSIP]};
    if (wr_enab) enab_d = {csr_wdata[PB_MTIP], csr_wdata[PB_STIP],
                           csr_wdata[PB_MSIP], csr_wdata[PB_SSIP]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
    end else begin
      if (wr_pend) pend_q <= pend_d;
      if (wr_enab) enab_q <= enab_d;
    end
  end

  always_comb begin
    pending_o          = '0;
    pending_o[PB_SSIP] = pend_q[0];
    pending_o[PB_MSIP] = pend_q[1];
    pending_o[PB_STIP] = pend_q[2];
    pending_o[PB_MTIP] = mtip;
    enable_o           = '0;
    enable_o[PB_SSIP]  = enab_q[0];
    enable_o[PB_MSIP]  = enab_q[1];
    enable_o[PB_STIP]  = enab_q[2];
    enable_o[PB_MTIP]  = enab_q[3];
  end

  assign live.s_sw  = pend_q[0] & enab_q[0];
  assign live.m_sw  = pend_q[1] & enab_q[1];
  assign live.s_tmr = pend_q[2] & enab_q[2];
  assign live.m_tmr = mtip      & enab_q[3];

  trapu_arb u_arb (
    .prv       (prv_cur),
    .ie        (ie_cur),
    .live      (live),
    .host_nz   (host_msg_nz),
    .irq_valid (irq_valid),
    .irq_code  (irq_code)
  );

  // ---- trap record ----
  logic [XLEN-1:0] cause_q, cause_d, epc_q, epc_d, vpc_q, vpc_d;
  logic            fire_q;

  always_comb begin
    cause_d = cause_q;
    epc_d   = epc_q;
    vpc_d   = vpc_q;
    if (take_any) begin
      cause_d = exc_go ? trap_cause : {1'b1, {(XLEN-1-CODE_W){1'b0}}, irq_code};
      epc_d   = cur_pc;
      vpc_d   = VEC_BASE + (XLEN'(prv_cur) << VEC_SHIFT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      vpc_q   <= START_PC;
      fire_q  <= 1'b0;
    end else begin
      if (take_any) begin
        cause_q <= cause_d;
        epc_q   <= epc_d;
        vpc_q   <= vpc_d;
      end
      fire_q <= take_any;
    end
  end

  assign cause_o     = cause_q;
  assign epc_o       = epc_q;
  assign vec_pc_o    = vpc_q;
  assign trap_fire_o = fire_q;

  // R3: vector offset follows the privilege held before the push
  assert_vector_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_any |=> (vec_pc_o == VEC_BASE + (XLEN'($past(prv_cur)) << VEC_SHIFT)) &&
                 (epc_o == $past(cur_pc)));

  // R5: an exception request always records its own cause
  assert_exc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (cause_o == $past(trap_cause)));

  // R8: interrupt causes carry the top bit
  assert_irq_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !trap_req) |=> cause_o[XLEN-1]);

  // R12: fire pulse follows exactly the taken traps
  assert_fire_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req || irq_valid) |=> trap_fire_o);

  assert_fire_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && !irq_valid) |=> !trap_fire_o);
endmodule

// File: tb/test_priv_trap_unit.sv
`timescale 1ns/1ps
module test_priv_trap_unit;
  localparam int XLEN = 64;
  localparam logic [63:0] IRQ = 64'h8000_0000_0000_0000;
  localparam logic [1:0] S_STAT = 2'd0, S_PEND = 2'd1, S_ENAB = 2'd2, S_TCMP = 2'd3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            trap_req, ret_req, host_msg_nz, csr_we;
  logic [XLEN-1:0] trap_cause, cur_pc, rtc, csr_wdata;
  logic [1:0]      csr_sel;
  logic [XLEN-1:0] status_o, pending_o, enable_o, cause_o, epc_o, vec_pc_o;
  logic            trap_fire_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  priv_trap_unit #(.XLEN(XLEN), .VEC_BASE(64'h100)) i_priv_trap_unit (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
    .cur_pc(cur_pc), .ret_req(ret_req), .host_msg_nz(host_msg_nz), .rtc(rtc),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .status_o(status_o), .pending_o(pending_o), .enable_o(enable_o),
    .cause_o(cause_o), .epc_o(epc_o), .vec_pc_o(vec_pc_o), .trap_fire_o(trap_fire_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trap_req = 0; ret_req = 0; host_msg_nz = 0; csr_we = 0;
    trap_cause = '0; cur_pc = '0; rtc = '0; csr_wdata = '0; csr_sel = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    csr_we = 1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 0; csr_wdata = '0;
  endtask

  task automatic trap(input logic [63:0] c, input logic [63:0] pc);
    trap_req = 1; trap_cause = c; cur_pc = pc;
    @(negedge clk);
    trap_req = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "status", status_o, 64'h96);
    chk("R1", "vec_pc", vec_pc_o, 64'h200);
    chk("R1", "cause", cause_o, 0);
    chk("R1", "epc", epc_o, 0);
    chk("R1", "pending", pending_o, 0);
    chk("R1", "enable", enable_o, 0);
    chk("R1", "fire", {63'd0, trap_fire_o}, 0);
  endtask

  task automatic t_push_pop();
    do_reset();
    trap(64'd5, 64'h1234);
    chk("R2", "status after push", status_o, 64'hB6);
    chk("R3", "vector from machine", vec_pc_o, 64'h1C0);
    chk("R3", "cause", cause_o, 64'd5);
    chk("R3", "epc", epc_o, 64'h1234);
    chk("R12", "fire high", {63'd0, trap_fire_o}, 1);
    @(negedge clk);
    chk("R12", "fire one cycle", {63'd0, trap_fire_o}, 0);
    ret_req = 1; @(negedge clk); ret_req = 0;
    chk("R4", "status after pop", status_o, 64'h56);
    chk("R4", "vec_pc kept", vec_pc_o, 64'h1C0);
    chk("R4", "cause kept", cause_o, 64'd5);
    chk("R4", "fire low on return", {63'd0, trap_fire_o}, 0);
  endtask

  task automatic t_vector();
    do_reset();
    wr(S_STAT, 64'h90);
    chk("R10", "write user prv", status_o, 64'h90);
    trap(64'd2, 64'h40);
    chk("R3", "vector from user", vec_pc_o, 64'h100);
    chk("R2", "push from user", status_o, 64'h86);
    do_reset();
    wr(S_STAT, 64'h92);
    trap(64'd2, 64'h44);
    chk("R3", "vector from supervisor", vec_pc_o, 64'h140);
    chk("R2", "push from supervisor", status_o, 64'h96);
  endtask

  task automatic t_filter();
    do_reset();
    wr(S_STAT, 64'h385);
    chk("R10", "reserved prv ignored", status_o, 64'h387);
    trap(64'd9, 64'h10);
    chk("R2", "push clears override", status_o, 64'h3E);
  endtask

  task automatic t_priority();
    do_reset();
    trap_req = 1; ret_req = 1; trap_cause = 64'd7; cur_pc = 64'h88;
    csr_we = 1; csr_sel = S_STAT; csr_wdata = 64'h0;
    @(negedge clk);
    trap_req = 0; ret_req = 0; csr_we = 0;
    chk("R5", "trap over return and write", status_o, 64'hB6);
    chk("R5", "cause", cause_o, 64'd7);
    ret_req = 1; csr_we = 1; csr_sel = S_STAT; csr_wdata = 64'h90;
    @(negedge clk);
    ret_req = 0; csr_we = 0;
    chk("R5", "return over write", status_o, 64'h56);
    // exception beats an interrupt armed in the same cycle
    do_reset();
    wr(S_ENAB, 64'hAA);
    wr(S_PEND, 64'h08);
    wr(S_STAT, 64'h97);
    trap_req = 1; ret_req = 1; trap_cause = 64'd3; cur_pc = 64'h60;
    @(negedge clk);
    trap_req = 0; ret_req = 0;
    chk("R5", "exception over interrupt cause", cause_o, 64'd3);
    chk("R5", "exception push", status_o, 64'hBE);
    // interrupt beats a return
    wr(S_STAT, 64'h97);
    ret_req = 1; cur_pc = 64'h64;
    @(negedge clk);
    ret_req = 0;
    chk("R5", "interrupt over return cause", cause_o, IRQ);
    chk("R5", "interrupt over return push", status_o, 64'hBE);
  endtask

  task automatic t_masks();
    do_reset();
    wr(S_PEND, '1);
    chk("R11", "pending write mask", pending_o, 64'h2A);
    wr(S_ENAB, '1);
    chk("R11", "enable write mask", enable_o, 64'hAA);
    chk("R11", "no trap while masked by prv", {63'd0, trap_fire_o}, 0);
    wr(S_PEND, 64'h0);
    chk("R11", "pending cleared", pending_o, 64'h0);
  endtask

  task automatic t_timer();
    do_reset();
    wr(S_TCMP, 64'd100);
    rtc = 64'd50; @(negedge clk);
    chk("R9", "below compare", pending_o, 64'h0);
    rtc = 64'd100; @(negedge clk);
    chk("R9", "equal sets", pending_o, 64'h80);
    rtc = 64'd0; @(negedge clk);
    chk("R9", "sticky", pending_o, 64'h80);
    wr(S_PEND, 64'h0);
    chk("R11", "timer bit not writable", pending_o, 64'h80);
    wr(S_TCMP, 64'd100);
    chk("R9", "compare write clears", pending_o, 64'h0);
    @(negedge clk);
    chk("R9", "stays clear", pending_o, 64'h0);
  endtask

  task automatic t_mtier();
    do_reset();
    cur_pc = 64'h500;
    wr(S_ENAB, 64'hAA);
    wr(S_PEND, 64'h0A);
    @(negedge clk);
    chk("R6", "machine ie off blocks", {63'd0, trap_fire_o}, 0);
    wr(S_STAT, 64'h97);
    @(negedge clk);
    chk("R6", "software first fire", {63'd0, trap_fire_o}, 1);
    chk("R8", "machine software cause", cause_o, IRQ | 64'd0);
    chk("R8", "epc from cur_pc", epc_o, 64'h500);
    chk("R3", "irq vector", vec_pc_o, 64'h1C0);
    chk("R2", "irq push", status_o, 64'hBE);
    wr(S_PEND, 64'h0);
    wr(S_TCMP, 64'd100);
    rtc = 64'd200; host_msg_nz = 1;
    @(negedge clk);
    wr(S_STAT, 64'h97);
    @(negedge clk);
    chk("R6", "timer before host", cause_o, IRQ | 64'd1);
    wr(S_TCMP, '1);
    @(negedge clk);
    wr(S_STAT, 64'h97);
    @(negedge clk);
    chk("R6", "host message cause", cause_o, IRQ | 64'd2);
    host_msg_nz = 0;
  endtask

  task automatic t_stier();
    do_reset();
    wr(S_ENAB, 64'hAA);
    wr(S_PEND, 64'h22);
    wr(S_STAT, 64'h92);
    @(negedge clk);
    chk("R7", "supervisor ie off blocks", {63'd0, trap_fire_o}, 0);
    wr(S_STAT, 64'h93);
    @(negedge clk);
    chk("R7", "supervisor software first", cause_o, IRQ | 64'd0);
    chk("R3", "vector from supervisor irq", vec_pc_o, 64'h140);
    wr(S_PEND, 64'h20);
    wr(S_STAT, 64'h90);
    @(negedge clk);
    chk("R7", "supervisor timer from user", cause_o, IRQ | 64'd1);
    chk("R3", "vector from user irq", vec_pc_o, 64'h100);
    wr(S_PEND, 64'h02);
    wr(S_TCMP, 64'd10);
    rtc = 64'd50;
    @(negedge clk);
    wr(S_ENAB, 64'h82);
    wr(S_STAT, 64'h90);
    @(negedge clk);
    chk("R7", "machine tier before supervisor", cause_o, IRQ | 64'd1);
    wr(S_ENAB, 64'h00);
    wr(S_STAT, 64'h90);
    @(negedge clk);
    chk("R8", "disabled sources ignored", {63'd0, trap_fire_o}, 0);
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_vector();
    t_filter();
    t_priority();
    t_masks();
    t_timer();
    t_mtier();
    t_stier();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule